// File: doc/BRIEF.md
# Serial Audio Word Packer

This block takes a three-wire serial audio stream (bit clock, word select, data) and turns it into 32-bit words for a host bus. There is no audio clock domain: the serial lines are sampled by the system clock, passed through synchronizers, and bit clock edges are found by comparing successive samples. Left and right samples of 16 or 24 bits are captured MSB first, one bit period after each word-select change.

Captured samples are packed into 32-bit words with no unused bits. In 16-bit mode each word carries one stereo pair. In 24-bit mode samples run across word boundaries, so one word holds a whole sample and the low byte of the next one, and four samples fill three words. Words go into a small FIFO that the host drains. The block pulses a ready flag each time a programmed number of words has been stored, so the host can move audio in multi-sample packets rather than one sample at a time. When the FIFO has no room for the next group of samples, that whole group is discarded and a sticky overrun flag is set. Discarding whole groups keeps the packing aligned.

Top module: `audioPacker`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, rdValid, pktReady and overrun are all 0.
- R2: The serial lines are sampled on clk through a two-stage synchronizer, and a data bit is taken at each detected rising edge of sckIn. Word select level 0 marks a left slot and 1 marks a right slot. A slot's sample is the first W bits after the edge at which word select changes, MSB first (W = 16 or 24). Later bits in the slot are ignored.
- R3: The slot in progress when the first word-select change after reset is seen is discarded. Right slots are discarded until a left slot has been captured, so packing always starts with a left sample.
- R4: With wideMode = 0, each stored word is {right[15:0], left[15:0]}, with the left sample in bits [15:0].
- R5: With wideMode = 1, accepted 24-bit samples are laid into a bit stream in arrival order, each sample's LSB first. Word k is stream bits [32k+31:32k], so every four samples give exactly three words.
- R6: Words leave in the order they were stored. rdData shows the oldest word while rdValid is 1, and a cycle with rdEn = 1 removes it. rdEn while rdValid is 0 has no effect.
- R7: pktReady is a one-cycle pulse, raised each time pktWords words (pktWords >= 1) have been stored since reset or since the previous pulse.
- R8: A group is one stereo pair in 16-bit mode or four samples in 24-bit mode. If, at the start of a group, the FIFO has fewer free words than the group produces (1 or 3), every sample of that group is discarded and overrun is set. Words already stored are kept, later groups are packed with normal alignment, and overrun stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| sckIn | input | 1 | Serial bit clock, asynchronous to clk |
| wsIn | input | 1 | Word select: 0 left, 1 right |
| sdIn | input | 1 | Serial data, MSB first |
| wideMode | input | 1 | 0: 16-bit samples, 1: 24-bit samples (held static between resets) |
| pktWords | input | PKT_W | Words per packet, at least 1 |
| rdEn | input | 1 | Remove the head word |
| rdData | output | 32 | Oldest stored word |
| rdValid | output | 1 | FIFO holds at least one word |
| pktReady | output | 1 | One-cycle pulse per completed packet |
| overrun | output | 1 | Sticky flag for discarded groups |

## Verification
A wrong packing phase or fill count shows up in the first stored word after the fault as misplaced byte lanes in rdData. In 24-bit mode the word count per four samples also goes wrong, so rdValid drops early or stays high after the expected words have been read. A slip in the bit counter or word-select tracking corrupts the very next sample. A packet counter fault shifts the pktReady pulse by whole words. A faulty room check either loses stored words or splits a group, and the first word after the host drains the FIFO exposes it.

// File: rtl/audioPackPkg.sv
package audioPackPkg;
  localparam int WORD_W = 32;
  localparam int MAX_SAMPLE_W = 24;

  typedef struct packed {
    logic shiftBit;
    logic slotEnd;
    logic accept;
  } packStrobes_t;
endpackage

// File: rtl/bitSync.sv
module bitSync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/packerCtrl.sv
module packerCtrl
  import audioPackPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PKT_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sckS,
  input  logic             wsS,
  input  logic             wideMode,
  input  logic [LVL_W-1:0] level,
  input  logic             wordWr,
  input  logic [PKT_W-1:0] pktWords,
  output packStrobes_t     strobe,
  output logic             pktReady,
  output logic             overrun
);
  logic             sckD;
  logic             wsLast;
  logic             slotValid;
  logic             started;
  logic [4:0]       bitCnt;
  logic [1:0]       phase;
  logic [1:0]       dropLeft;
  logic [PKT_W-1:0] pktCnt;

  logic             rise, wsEdge, eligible, isRight;
  logic             groupStart, roomOk, dropStart;
  logic [4:0]       sampleBits;
  logic [1:0]       groupLast;
  logic [LVL_W:0]   freeWords, groupWords;
  logic [PKT_W-1:0] pktNext;

  always_comb begin
    rise       = sckS & ~sckD;
    wsEdge     = rise && (wsS != wsLast);
    sampleBits = wideMode ? 5'd24 : 5'd16;
    groupLast  = wideMode ? 2'd3 : 2'd1;
    groupWords = wideMode ? (LVL_W+1)'(3) : (LVL_W+1)'(1);
    freeWords  = (LVL_W+1)'(DEPTH) - {1'b0, level};
    isRight    = wsLast;
    eligible   = wsEdge && slotValid && (started || !isRight);
    groupStart = eligible && (dropLeft == 2'd0) && (phase == 2'd0);
    roomOk     = freeWords >= groupWords;
    dropStart  = groupStart && !roomOk;

    strobe.shiftBit = rise && (bitCnt < sampleBits);
    strobe.slotEnd  = wsEdge && slotValid;
    strobe.accept   = eligible && (dropLeft == 2'd0) && ((phase != 2'd0) || roomOk);
    pktNext         = pktCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckD      <= 1'b0;
      wsLast    <= 1'b0;
      slotValid <= 1'b0;
      started   <= 1'b0;
      bitCnt    <= '0;
      phase     <= '0;
      dropLeft  <= '0;
      overrun   <= 1'b0;
      pktCnt    <= '0;
      pktReady  <= 1'b0;
    end else begin
      sckD <= sckS;
      if (rise) wsLast <= wsS;
      if (wsEdge) slotValid <= 1'b1;
      if (eligible && !isRight) started <= 1'b1;

      if (wsEdge) bitCnt <= '0;
      else if (rise && bitCnt != 5'd31) bitCnt <= bitCnt + 1'b1;

      if (strobe.accept) phase <= (phase == groupLast) ? 2'd0 : phase + 1'b1;

      if (dropStart) begin
        dropLeft <= groupLast;
        overrun  <= 1'b1;
      end else if (eligible && dropLeft != 2'd0) begin
        dropLeft <= dropLeft - 1'b1;
      end

      pktReady <= 1'b0;
      if (wordWr) begin
        if (pktNext == pktWords) begin
          pktReady <= 1'b1;
          pktCnt   <= '0;
        end else begin
          pktCnt <= pktNext;
        end
      end
    end
  end
endmodule

// File: rtl/packerData.sv
module packerData
  import audioPackPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdS,
  input  logic              wideMode,
  input  packStrobes_t      strobe,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic              wordWr,
  output logic [LVL_W-1:0]  level
);
  logic [MAX_SAMPLE_W-1:0] shreg, shNext, sample;
  logic [WORD_W-1:0]       acc;
  logic [5:0]              fill, sumFill;
  logic [2*WORD_W-1:0]     merged;
  logic [WORD_W-1:0]       mem [DEPTH];
  logic [AW-1:0]           wrPtr, rdPtr;
  logic                    doPop;

  always_comb begin
    shNext  = strobe.shiftBit ? {shreg[MAX_SAMPLE_W-2:0], sdS} : shreg;
    sample  = wideMode ? shNext : {8'b0, shNext[15:0]};
    sumFill = fill + (wideMode ? 6'd24 : 6'd16);
    merged  = {32'b0, acc} | ({40'b0, sample} << fill);
    wordWr  = strobe.accept && (sumFill >= 6'd32);
    doPop   = rdEn && (level != '0);
    rdValid = level != '0;
    rdData  = mem[rdPtr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shreg <= '0;
      acc   <= '0;
      fill  <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      shreg <= shNext;
      if (strobe.accept) begin
        if (sumFill >= 6'd32) begin
          acc  <= merged[2*WORD_W-1:WORD_W];
          fill <= sumFill - 6'd32;
        end else begin
          acc  <= merged[WORD_W-1:0];
          fill <= sumFill;
        end
      end
      if (wordWr) wrPtr <= wrPtr + 1'b1;
      if (doPop) rdPtr <= rdPtr + 1'b1;
      level <= level + LVL_W'(wordWr) - LVL_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (wordWr) mem[wrPtr] <= merged[WORD_W-1:0];
  end
endmodule

// File: rtl/audioPacker.sv
module audioPacker
  import audioPackPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PKT_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              wsIn,
  input  logic              sdIn,
  input  logic              wideMode,
  input  logic [PKT_W-1:0]  pktWords,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic              pktReady,
  output logic              overrun
);
  logic [2:0]       lineSync;
  packStrobes_t     strobe;
  logic             wordWr;
  logic [LVL_W-1:0] wordLevel;

  bitSync #(.WIDTH(3), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .din({sckIn, wsIn, sdIn}), .dout(lineSync)
  );

  packerCtrl #(.DEPTH(DEPTH), .PKT_W(PKT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sckS(lineSync[2]), .wsS(lineSync[1]),
    .wideMode(wideMode), .level(wordLevel), .wordWr(wordWr),
    .pktWords(pktWords), .strobe(strobe), .pktReady(pktReady), .overrun(overrun)
  );

  packerData #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .sdS(lineSync[0]), .wideMode(wideMode),
    .strobe(strobe), .rdEn(rdEn), .rdData(rdData), .rdValid(rdValid),
    .wordWr(wordWr), .level(wordLevel)
  );
endmodule

// File: rtl/audioPackerChecker.sv
module audioPackerChecker #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             rdEn,
  input logic             rdValid,
  input logic [31:0]      rdData,
  input logic             pktReady,
  input logic             overrun,
  input logic [LVL_W-1:0] level
);
  // R8: overrun holds once set
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R7: the ready flag lasts a single cycle
  a_r7_ready_pulse: assert property (@(posedge clk) disable iff (!rstN)
    pktReady |=> !pktReady);

  // R7: a completed packet implies stored data
  a_r7_ready_has_data: assert property (@(posedge clk) disable iff (!rstN)
    pktReady |-> rdValid);

  // R6: the head word stays put until it is read
  a_r6_head_stable: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdEn) |=> (rdValid && $stable(rdData)));

  // R8: the room check keeps the FIFO from overfilling
  a_r8_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));
endmodule

bind audioPacker audioPackerChecker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) uChk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdValid(rdValid), .rdData(rdData),
  .pktReady(pktReady), .overrun(overrun), .level(wordLevel)
);

// File: tb/sim_audioPacker.sv
module sim_audioPacker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sckIn = 1'b0, wsIn = 1'b0, sdIn = 1'b0;
  logic        wideMode = 1'b0;
  logic [7:0]  pktWords = 8'd255;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        rdValid, pktReady, overrun;

  int checks = 0;
  int errors = 0;
  int pulses = 0;

  always #4 clk = ~clk;

  audioPacker u0 (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .wsIn(wsIn), .sdIn(sdIn),
    .wideMode(wideMode), .pktWords(pktWords), .rdEn(rdEn),
    .rdData(rdData), .rdValid(rdValid), .pktReady(pktReady), .overrun(overrun)
  );

  always @(negedge clk) if (rstN && pktReady) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic wide, input logic [7:0] pkt);
    @(negedge clk);
    rstN = 1'b0; wideMode = wide; pktWords = pkt; rdEn = 1'b0;
    sckIn = 1'b0; wsIn = 1'b0; sdIn = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    pulses = 0;
  endtask

  task automatic sendSlot(input logic ch, input logic [23:0] s, input int w);
    for (int i = 0; i < 32; i++) begin
      sckIn = 1'b0;
      wsIn = (i == 31) ? ~ch : ch;
      sdIn = (i < w) ? s[w-1-i] : 1'b1;
      repeat (4) @(negedge clk);
      sckIn = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic sendPair(input logic [23:0] l, input logic [23:0] r);
    int w;
    w = wideMode ? 24 : 16;
    sendSlot(1'b0, l, w);
    sendSlot(1'b1, r, w);
    repeat (4) @(negedge clk);
  endtask

  task automatic popCheck(input string req, input logic [31:0] exp);
    chk({req, " valid"}, 32'(rdValid), 32'd1);
    chk(req, rdData, exp);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [23:0] smp(input int k);
    return 24'(32'h00A5_3C1F ^ (k * 32'h0013_5797));
  endfunction

  task automatic testReset;
    doReset(1'b0, 8'd255);
    chk("R1 rdValid", 32'(rdValid), 0);
    chk("R1 pktReady", 32'(pktReady), 0);
    chk("R1 overrun", 32'(overrun), 0);
    rdEn = 1'b1; @(negedge clk); rdEn = 1'b0; @(negedge clk);
    chk("R6 read on empty ignored", 32'(rdValid), 0);
  endtask

  task automatic testNarrow;
    doReset(1'b0, 8'd255);
    sendPair(24'h00DEAD, 24'h00BEEF);
    chk("R3 preamble discarded", 32'(rdValid), 0);
    sendPair(24'h001234, 24'h00ABCD);
    sendPair(24'h008001, 24'h007FFE);
    sendPair(24'h00FFFF, 24'h000000);
    popCheck("R4 pair0", 32'hABCD_1234);
    popCheck("R2 pair1", 32'h7FFE_8001);
    popCheck("R4 pair2", 32'h0000_FFFF);
    chk("R6 drained", 32'(rdValid), 0);
  endtask

  task automatic testWide;
    logic [95:0] st;
    doReset(1'b1, 8'd255);
    sendPair(24'h111111, 24'h222222);
    sendPair(24'h123456, 24'h89ABCD);
    sendPair(24'hFEDCBA, 24'h0F1E2D);
    st = {24'h0F1E2D, 24'hFEDCBA, 24'h89ABCD, 24'h123456};
    popCheck("R5 word0", st[31:0]);
    popCheck("R5 word1", st[63:32]);
    popCheck("R5 word2", st[95:64]);
    chk("R5 three words per four samples", 32'(rdValid), 0);
  endtask

  task automatic testPacket;
    doReset(1'b0, 8'd3);
    sendPair(24'h0, 24'h0);
    sendPair(24'h0001, 24'h0002);
    sendPair(24'h0003, 24'h0004);
    chk("R7 no pulse at 2 words", 32'(pulses), 0);
    sendPair(24'h0005, 24'h0006);
    chk("R7 pulse at 3 words", 32'(pulses), 1);
    sendPair(24'h0007, 24'h0008);
    sendPair(24'h0009, 24'h000A);
    sendPair(24'h000B, 24'h000C);
    chk("R7 pulse at 6 words", 32'(pulses), 2);
  endtask

  task automatic testOverrunNarrow;
    doReset(1'b0, 8'd255);
    sendPair(24'h0, 24'h0);
    for (int i = 0; i < 16; i++) sendPair(24'(i), 24'(i + 100));
    chk("R8 no overrun while room", 32'(overrun), 0);
    sendPair(24'h00EEEE, 24'h00DDDD);
    chk("R8 overrun set", 32'(overrun), 1);
    for (int i = 0; i < 16; i++) popCheck("R6 order kept", {16'(i + 100), 16'(i)});
    chk("R8 dropped pair absent", 32'(rdValid), 0);
    sendPair(24'h00AAAA, 24'h005555);
    popCheck("R8 alignment after drop", 32'h5555_AAAA);
    chk("R8 overrun sticky", 32'(overrun), 1);
  endtask

  task automatic testOverrunWide;
    logic [479:0] st;
    logic [95:0]  g;
    doReset(1'b1, 8'd255);
    sendPair(24'h0, 24'h0);
    for (int k = 0; k < 20; k += 2) begin
      sendPair(smp(k), smp(k + 1));
      st[k*24 +: 24]       = smp(k);
      st[(k + 1)*24 +: 24] = smp(k + 1);
    end
    chk("R8 wide no overrun at 15 words", 32'(overrun), 0);
    sendPair(24'hAAAAAA, 24'hBBBBBB);
    sendPair(24'hCCCCCC, 24'hDDDDDD);
    chk("R8 wide group dropped", 32'(overrun), 1);
    for (int i = 0; i < 15; i++) popCheck("R8 wide stored words", st[i*32 +: 32]);
    chk("R8 wide whole group gone", 32'(rdValid), 0);
    sendPair(smp(40), smp(41));
    sendPair(smp(42), smp(43));
    g = {smp(43), smp(42), smp(41), smp(40)};
    popCheck("R8 wide realign w0", g[31:0]);
    popCheck("R8 wide realign w1", g[63:32]);
    popCheck("R8 wide realign w2", g[95:64]);
  endtask

  initial begin
    testReset();
    testNarrow();
    testWide();
    testPacket();
    testOverrunNarrow();
    testOverrunWide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule